// File: doc/BRIEF.md
# Low-Voltage Programming Key Detector

This block sits beside a two-wire serial programming port. The port has a programming clock pin and a data pin. The block also watches an active-low reset/mode pin. When a configuration bit allows low-voltage entry and the mode pin is held low, the block shifts in a 32-bit key from the data pin, one bit on each falling edge of the programming clock. If the key matches the fixed pattern 0x4D434850 exactly, the device enters program/verify mode.

While the mode is active, the block does three things:
- It keeps the rest of the device logic in reset.
- It turns the general-purpose pins into high-impedance inputs.
- On entry only, it gives a one-cycle pulse that clears the program address counter.

Raising the mode pin leaves the mode. It also empties the key register, so every attempt starts fresh. The block does not decode commands that follow entry.

All three external pins are asynchronous. They pass through a two-stage synchronizer into the system clock domain, and the clock's falling edge is found from the synchronized samples.

Top module: `lv_key_entry`

## Requirements
- R1: After system reset, `prog_mode_o`, `hold_reset_o`, `io_tristate_o` and `addr_clear_o` are all 0.
- R2: With `lv_enable_i`=1 and `mode_pin_n_i` held at 0, shifting 0x4D434850 in 32 bits, bit 0 first, sets `prog_mode_o`, `hold_reset_o` and `io_tristate_o` to 1.
- R3: `addr_clear_o` is high for exactly one system cycle per entry, in the first cycle that `prog_mode_o` is 1.
- R4: A data bit is taken from the data pin on the falling edge of the programming clock. The value present at the rising edge has no effect.
- R5: When `lv_enable_i`=0, a correct key does not enter the mode.
- R6: Clock edges while `mode_pin_n_i`=1 shift nothing and cannot enter the mode.
- R7: Any 32-bit word other than the key leaves all mode outputs at 0. This includes every single-bit corruption of the key and the key sent most significant bit first.
- R8: After a 32-bit mismatch, further bits do not enter the mode until the mode pin goes high and then low again.
- R9: Driving `mode_pin_n_i` to 1 while in the mode clears `prog_mode_o`, `hold_reset_o` and `io_tristate_o`.
- R10: A partial key abandoned by raising the mode pin is discarded. A full key sent after the pin goes low again enters the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| pgm_clk_i | input | 1 | Programming clock pin, asynchronous |
| pgm_dat_i | input | 1 | Programming data pin, asynchronous |
| mode_pin_n_i | input | 1 | Active-low reset/mode pin, asynchronous |
| lv_enable_i | input | 1 | Low-voltage entry configuration enable |
| prog_mode_o | output | 1 | Program/verify mode active |
| hold_reset_o | output | 1 | Hold remaining logic in reset |
| io_tristate_o | output | 1 | Force general-purpose pins to high-impedance inputs |
| addr_clear_o | output | 1 | One-cycle pulse to clear the program address counter |

## Verification
The assertions check a set of rules on every cycle:
- A high synchronized mode pin empties the detector and drops the mode on the next cycle.
- With the enable off, the mode is never entered.
- A mismatch on the last bit locks the detector out.
- The address-clear pulse lasts one cycle and only comes with entry.

Other behaviour can only be shown by the bench's scenarios:
- The exact key value and its bit-0-first order.
- Sampling on the falling edge rather than the rising edge.
- Rejection of every single-bit corruption of the key.
- A clean restart after an abandoned attempt.

// File: rtl/lv_key_entry.sv
module lv_key_entry #(
  parameter int          KEY_W       = 32,
  parameter logic [31:0] KEY_VALUE   = 32'h4D434850,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_clk_i,
  input  logic pgm_dat_i,
  input  logic mode_pin_n_i,
  input  logic lv_enable_i,
  output logic prog_mode_o,
  output logic hold_reset_o,
  output logic io_tristate_o,
  output logic addr_clear_o
);

  localparam int CW = $clog2(KEY_W + 1);
  localparam logic [KEY_W-1:0] KEY = KEY_VALUE[KEY_W-1:0];

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync, pin_sync;
  logic                   clk_d;
  logic [KEY_W-1:0]       shreg_q;
  logic [CW-1:0]          cnt_q;
  logic                   prog_q, locked_q, clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      pin_sync <= '1;
      clk_d    <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], pgm_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], pgm_dat_i};
      pin_sync <= {pin_sync[SYNC_STAGES-2:0], mode_pin_n_i};
      clk_d    <= clk_sync[SYNC_STAGES-1];
    end
  end

  wire clk_s  = clk_sync[SYNC_STAGES-1];
  wire dat_s  = dat_sync[SYNC_STAGES-1];
  wire pin_hi = pin_sync[SYNC_STAGES-1];
  wire fall   = clk_d & ~clk_s;

  wire shift_en = fall & ~pin_hi & lv_enable_i & ~prog_q & ~locked_q;
  wire last_bit = shift_en && (cnt_q == CW'(KEY_W - 1));
  wire [KEY_W-1:0] shreg_nxt = {dat_s, shreg_q[KEY_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      prog_q   <= 1'b0;
      locked_q <= 1'b0;
      clr_q    <= 1'b0;
    end else if (pin_hi) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      prog_q   <= 1'b0;
      locked_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (shift_en) begin
        shreg_q <= shreg_nxt;
        cnt_q   <= cnt_q + 1'b1;
        if (last_bit) begin
          if (shreg_nxt == KEY) begin
            prog_q <= 1'b1;
            clr_q  <= 1'b1;
          end else begin
            locked_q <= 1'b1;
          end
        end
      end
    end
  end

  assign prog_mode_o   = prog_q;
  assign hold_reset_o  = prog_q;
  assign io_tristate_o = prog_q;
  assign addr_clear_o  = clr_q;

  a_r3_clear_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_q) |-> clr_q);
  a_r3_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  a_r3_clear_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> prog_q);
  a_r9_pin_high_exits: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hi |=> (!prog_q && cnt_q == '0));
  a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv_enable_i && !prog_q) |=> !prog_q);
  a_r8_locked_stays_out: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> !prog_q);
  a_r7_mismatch_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && shreg_nxt != KEY) |=> (locked_q && !prog_q));

endmodule

// File: tb/lv_key_entry_bench.sv
module lv_key_entry_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h4D434850;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pgm_clk = 1'b0, pgm_dat = 1'b0, mode_n = 1'b1, lv_en = 1'b1;
  logic prog_mode, hold_rst, io_tri, addr_clr;
  int checks = 0, errors = 0, pulse_cnt = 0, pulse_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lv_key_entry u_lv_key_entry (
    .clk(clk), .rst_n(rst_n), .pgm_clk_i(pgm_clk), .pgm_dat_i(pgm_dat),
    .mode_pin_n_i(mode_n), .lv_enable_i(lv_en), .prog_mode_o(prog_mode),
    .hold_reset_o(hold_rst), .io_tristate_o(io_tri), .addr_clear_o(addr_clr)
  );

  always @(posedge clk) begin
    if (addr_clr) begin
      pulse_cnt <= pulse_cnt + 1;
      if (!prog_mode) pulse_bad <= pulse_bad + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R4: the wrong value is present at the rising edge, the right one at the falling edge
  task automatic send_bit(input logic b);
    pgm_dat = ~b;
    wait_cyc(3);
    pgm_clk = 1'b1;
    wait_cyc(1);
    pgm_dat = b;
    wait_cyc(3);
    pgm_clk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, input bit msb_first);
    for (int i = 0; i < n; i++) send_bit(msb_first ? w[31-i] : w[i]);
    wait_cyc(6);
  endtask

  task automatic pin_low();  mode_n = 1'b0; wait_cyc(5); endtask
  task automatic pin_high(); mode_n = 1'b1; wait_cyc(6); endtask

  task automatic check_mode(input bit exp, input string tag);
    check(prog_mode == exp, tag, prog_mode, exp);
    check(hold_rst == exp, tag, hold_rst, exp);
    check(io_tri == exp, tag, io_tri, exp);
  endtask

  initial begin
    wait_cyc(5);
    // R1
    check_mode(1'b0, "R1 reset outputs");
    check(addr_clr == 1'b0, "R1 addr clear", addr_clr, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check_mode(1'b0, "R1 after reset release");

    // R2, R3, R4
    pin_low();
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b1, "R2 key entry");
    check(pulse_cnt == 1, "R3 one clear pulse", pulse_cnt, 1);
    check(pulse_bad == 0, "R3 pulse with mode", pulse_bad, 0);
    wait_cyc(10);
    check(pulse_cnt == 1, "R3 no further pulse", pulse_cnt, 1);
    // R9
    pin_high();
    check_mode(1'b0, "R9 exit on pin high");

    // R5
    lv_en = 1'b0;
    pin_low();
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b0, "R5 disabled ignores key");
    lv_en = 1'b1;
    pin_high();

    // R6
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b0, "R6 pin high ignores key");
    pin_low();
    send_bits(KEY, 1, 1'b0);
    check_mode(1'b0, "R6 nothing retained");
    pin_high();

    // R7
    for (int i = 0; i < 32; i++) begin
      pin_low();
      send_bits(KEY ^ (32'h1 << i), 32, 1'b0);
      check_mode(1'b0, $sformatf("R7 bit %0d flipped", i));
      pin_high();
    end
    pin_low();
    send_bits(KEY, 32, 1'b1);
    check_mode(1'b0, "R7 msb first rejected");
    pin_high();

    // R8
    pin_low();
    send_bits(~KEY, 32, 1'b0);
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b0, "R8 locked after mismatch");
    pin_high();
    pin_low();
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b1, "R8 retry after pin toggle");
    check(pulse_cnt == 2, "R3 second pulse", pulse_cnt, 2);
    pin_high();

    // R10
    pin_low();
    send_bits(32'h3FF, 10, 1'b0);
    pin_high();
    pin_low();
    send_bits(KEY, 32, 1'b0);
    check_mode(1'b1, "R10 restart after partial");
    pin_high();
    check_mode(1'b0, "R9 exit again");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule